// File: doc/BRIEF.md
# Virtual APIC Access Policy Unit

This block stands between a guest's APIC register-access port and a small backing store that keeps the guest's virtual APIC state. Each guest access carries a 12-bit register offset and a direction. The block looks up a fixed policy for that offset and direction and resolves the access to one of four actions. An ALLOWED access reads or writes the store and nothing else happens. An ACCELERATED access also reads or writes the store, and may additionally fire a hardware side-action pulse. A TRAP access updates the store and then flags an exit to the hypervisor. A FAULT access never touches the store and flags an exit in place of the access.

An exit is latched together with its code, the offending offset, the direction, and whether it came after the access (trap) or in place of it (fault). It stays up until the hypervisor acknowledges it. While an exit is pending, the guest port is stalled. Two side-actions leave the block as single-cycle pulses: an IPI send request for a supported interrupt-command write and an end-of-interrupt notification. Their delivery happens elsewhere.

Top module: `vapic_access_policy`

## Requirements
- R1: After reset no exit is pending, the port is ready, both side-action pulses are low, and every stored register reads 0.
- R2: The interrupt-command high word at offset 310h is ALLOWED in both directions. A write is stored, a read returns it in the same cycle as the access, and neither raises an exit.
- R3: Task-priority (080h) reads and writes and end-of-interrupt (0B0h) writes are ACCELERATED: the store is updated and no exit is raised. An end-of-interrupt write also drives eoi_req_o high for exactly the one cycle after the access.
- R4: A write to the interrupt-command low word (300h) with ipi_supported_i high is ACCELERATED. The word is stored, ipi_req_o is high for the one cycle after the access, and no exit is raised.
- R5: A write to 300h with ipi_supported_i low is a TRAP. The word is stored, no IPI pulse is made, and an exit is raised with code 401h, exit_trap_o = 1 and exit_write_o = 1.
- R6: The eight request words at 200h, 210h, ..., 270h are ALLOWED on read and FAULT on write. A faulting write leaves the word unchanged and raises an exit with code 402h, exit_trap_o = 0, exit_write_o = 1 and the offset.
- R7: Any offset outside the policy table (including any offset with a nonzero low nibble) FAULTs in both directions. A faulting read returns 0. The exit has code 402h, exit_trap_o = 0, and exit_write_o giving the direction (1 = write).
- R8: Writes to the ID word (020h) and the logical-destination word (0D0h) are TRAPs. The word is stored and an exit with code 402h and exit_trap_o = 1 is raised. Reads of both are ALLOWED.
- R9: Exit outputs appear in the cycle after the access and hold steady until exit_ack_i is sampled high. While an exit is pending, acc_ready_o is low and offered accesses have no effect on the store or the exit fields.
- R10: Readiness comes from the registered exit state. An access offered in the same cycle as the acknowledge is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Guest access offered |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_offset_i | input | 12 | APIC register offset |
| acc_wdata_i | input | DATA_W | Write data |
| ipi_supported_i | input | 1 | Interrupt-command write is of a type the hardware can send |
| acc_ready_o | output | 1 | Access accepted this cycle if offered |
| acc_rdata_o | output | DATA_W | Read data of an accepted non-faulting read, else 0 |
| ipi_req_o | output | 1 | One-cycle IPI send request |
| eoi_req_o | output | 1 | One-cycle end-of-interrupt notification |
| exit_valid_o | output | 1 | Exit pending |
| exit_code_o | output | 12 | Exit code (401h or 402h) |
| exit_offset_o | output | 12 | Offset of the access that exited |
| exit_write_o | output | 1 | Direction of the access that exited |
| exit_trap_o | output | 1 | 1 = exit after the access (trap), 0 = in place of it (fault) |
| exit_ack_i | input | 1 | Hypervisor acknowledge |

## Verification
Two functions can land in the same cycle: the hypervisor's acknowledge that retires a pending exit, and the guest offering its next access. The bench raises an exit, then in one cycle drives the acknowledge together with a write to the allowed high command word. It then checks that the exit has cleared, and that a later read still returns the old word, which shows the colliding write was not accepted. A second overlap is a side-action pulse against an exit. A supported command write must produce the IPI pulse with no exit. An unsupported one must produce the exit with no pulse.

// File: rtl/vapic_pkg.sv
package vapic_pkg;

  typedef enum logic [1:0] {
    ACT_ALLOW = 2'd0,
    ACT_ACCEL = 2'd1,
    ACT_TRAP  = 2'd2,
    ACT_FAULT = 2'd3
  } act_e;

  localparam logic [11:0] OFF_ID   = 12'h020;
  localparam logic [11:0] OFF_TPR  = 12'h080;
  localparam logic [11:0] OFF_EOI  = 12'h0B0;
  localparam logic [11:0] OFF_LDR  = 12'h0D0;
  localparam logic [11:0] OFF_IRR0 = 12'h200;
  localparam logic [11:0] OFF_ICRL = 12'h300;
  localparam logic [11:0] OFF_ICRH = 12'h310;

  localparam logic [11:0] EXIT_IPI_FAIL = 12'h401;
  localparam logic [11:0] EXIT_UNACCEL  = 12'h402;

  localparam int S_ID   = 0;
  localparam int S_TPR  = 1;
  localparam int S_EOI  = 2;
  localparam int S_LDR  = 3;
  localparam int S_ICRL = 4;
  localparam int S_ICRH = 5;
  localparam int S_IRR0 = 6;

endpackage

// File: rtl/vapic_policy_dec.sv
module vapic_policy_dec
  import vapic_pkg::*;
#(
  parameter int NUM_IRR = 8,
  parameter int SLOT_W  = 4
) (
  input  logic [11:0]       off_i,
  input  logic              write_i,
  input  logic              ipi_ok_i,
  output act_e              act_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [11:0]       code_o
);

  always_comb begin
    act_o  = ACT_FAULT;
    slot_o = '0;
    unique case (off_i)
      OFF_ID: begin
        slot_o = SLOT_W'(S_ID);
        act_o  = write_i ? ACT_TRAP : ACT_ALLOW;
      end
      OFF_TPR: begin
        slot_o = SLOT_W'(S_TPR);
        act_o  = ACT_ACCEL;
      end
      OFF_EOI: begin
        slot_o = SLOT_W'(S_EOI);
        act_o  = write_i ? ACT_ACCEL : ACT_ALLOW;
      end
      OFF_LDR: begin
        slot_o = SLOT_W'(S_LDR);
        act_o  = write_i ? ACT_TRAP : ACT_ALLOW;
      end
      OFF_ICRL: begin
        slot_o = SLOT_W'(S_ICRL);
        if (!write_i)      act_o = ACT_ALLOW;
        else if (ipi_ok_i) act_o = ACT_ACCEL;
        else               act_o = ACT_TRAP;
      end
      OFF_ICRH: begin
        slot_o = SLOT_W'(S_ICRH);
        act_o  = ACT_ALLOW;
      end
      default: begin
        for (int k = 0; k < NUM_IRR; k++) begin
          if (off_i == OFF_IRR0 + 12'(k * 16)) begin
            slot_o = SLOT_W'(S_IRR0 + k);
            act_o  = write_i ? ACT_FAULT : ACT_ALLOW;
          end
        end
      end
    endcase
  end

  // failed IPI write gets its own code; every other exit is an unaccelerated access
  assign code_o = (write_i && off_i == OFF_ICRL) ? EXIT_IPI_FAIL : EXIT_UNACCEL;

endmodule

// File: rtl/vapic_backing_store.sv
module vapic_backing_store #(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 14,
  parameter int SLOT_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= '0;
      else if (we_i && slot_i == SLOT_W'(g))      mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (slot_i == SLOT_W'(k)) rdata_o = mem_q[k];
    end
  end

endmodule

// File: rtl/vapic_exit_ctl.sv
module vapic_exit_ctl (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        set_i,
  input  logic [11:0] code_i,
  input  logic [11:0] off_i,
  input  logic        write_i,
  input  logic        trap_i,
  input  logic        ack_i,
  output logic        valid_o,
  output logic [11:0] code_o,
  output logic [11:0] off_o,
  output logic        write_o,
  output logic        trap_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
      off_o   <= '0;
      write_o <= 1'b0;
      trap_o  <= 1'b0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      code_o  <= code_i;
      off_o   <= off_i;
      write_o <= write_i;
      trap_o  <= trap_i;
    end else if (ack_i) begin
      valid_o <= 1'b0;
    end
  end

  // R9
  exit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ack_i |=> valid_o && $stable(code_o) && $stable(off_o)
                          && $stable(write_o) && $stable(trap_o));

endmodule

// File: rtl/vapic_access_policy.sv
module vapic_access_policy
  import vapic_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_IRR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [11:0]       acc_offset_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  input  logic              ipi_supported_i,
  output logic              acc_ready_o,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic              ipi_req_o,
  output logic              eoi_req_o,
  output logic              exit_valid_o,
  output logic [11:0]       exit_code_o,
  output logic [11:0]       exit_offset_o,
  output logic              exit_write_o,
  output logic              exit_trap_o,
  input  logic              exit_ack_i
);

  localparam int NUM_SLOTS = S_IRR0 + NUM_IRR;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  act_e              act;
  logic [SLOT_W-1:0] slot;
  logic [11:0]       code;
  logic [DATA_W-1:0] store_rdata;
  logic              fire, store_we, exit_set;
  logic              ipi_q, eoi_q;

  vapic_policy_dec #(.NUM_IRR(NUM_IRR), .SLOT_W(SLOT_W)) i_dec (
    .off_i    (acc_offset_i),
    .write_i  (acc_write_i),
    .ipi_ok_i (ipi_supported_i),
    .act_o    (act),
    .slot_o   (slot),
    .code_o   (code)
  );

  assign acc_ready_o = !exit_valid_o;
  assign fire        = acc_valid_i && acc_ready_o;
  assign store_we    = fire && acc_write_i && act != ACT_FAULT;
  assign exit_set    = fire && (act == ACT_TRAP || act == ACT_FAULT);
  assign acc_rdata_o = (fire && !acc_write_i && act != ACT_FAULT) ? store_rdata : '0;

  vapic_backing_store #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (store_we),
    .slot_i  (slot),
    .wdata_i (acc_wdata_i),
    .rdata_o (store_rdata)
  );

  vapic_exit_ctl i_exit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (exit_set),
    .code_i  (code),
    .off_i   (acc_offset_i),
    .write_i (acc_write_i),
    .trap_i  (act == ACT_TRAP),
    .ack_i   (exit_ack_i),
    .valid_o (exit_valid_o),
    .code_o  (exit_code_o),
    .off_o   (exit_offset_o),
    .write_o (exit_write_o),
    .trap_o  (exit_trap_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipi_q <= 1'b0;
      eoi_q <= 1'b0;
    end else begin
      ipi_q <= fire && acc_write_i && act == ACT_ACCEL && acc_offset_i == OFF_ICRL;
      eoi_q <= fire && acc_write_i && act == ACT_ACCEL && acc_offset_i == OFF_EOI;
    end
  end

  assign ipi_req_o = ipi_q;
  assign eoi_req_o = eoi_q;

  // R4
  accel_no_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipi_req_o |-> !exit_valid_o);

  // R5
  icr_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && acc_write_i && acc_offset_i == OFF_ICRL && !ipi_supported_i
    |=> exit_valid_o && exit_trap_o && exit_code_o == EXIT_IPI_FAIL && !ipi_req_o);

  // R6
  fault_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && act == ACT_FAULT |=> exit_valid_o && !exit_trap_o
                                 && exit_code_o == EXIT_UNACCEL);

  // R10
  no_fire_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_valid_o && acc_valid_i |=> $stable(exit_offset_o) && !ipi_req_o && !eoi_req_o);

endmodule

// File: tb/test_vapic_access_policy.sv
`timescale 1ns/1ps
module test_vapic_access_policy;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0, wr = 1'b0, ipi_ok = 1'b0, ack = 1'b0;
  logic [11:0]   off = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, ipi_req, eoi_req, ex_valid, ex_write, ex_trap;
  logic [DW-1:0] rdata;
  logic [11:0]   ex_code, ex_off;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] last_rd;

  always #2 clk = ~clk;

  vapic_access_policy i_vapic_access_policy (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(wr),
    .acc_offset_i(off), .acc_wdata_i(wdata), .ipi_supported_i(ipi_ok),
    .acc_ready_o(ready), .acc_rdata_o(rdata), .ipi_req_o(ipi_req), .eoi_req_o(eoi_req),
    .exit_valid_o(ex_valid), .exit_code_o(ex_code), .exit_offset_o(ex_off),
    .exit_write_o(ex_write), .exit_trap_o(ex_trap), .exit_ack_i(ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // offer one access at negedge, accepted at next posedge; returns at following negedge
  task automatic access(input bit w, input logic [11:0] o, input logic [DW-1:0] d);
    @(negedge clk);
    valid = 1'b1; wr = w; off = o; wdata = d;
    #1 last_rd = rdata;
    @(negedge clk);
    valid = 1'b0; wr = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic check_exit(input string req, input logic [11:0] code, input logic [11:0] o,
                            input bit w, input bit trap);
    chk(ex_valid == 1'b1, req, ex_valid, 1);
    chk(ex_code == code, req, ex_code, code);
    chk(ex_off == o, req, ex_off, o);
    chk(ex_write == w && ex_trap == trap, req, {ex_write, ex_trap}, {w, trap});
  endtask

  task automatic t_reset();
    chk(ready && !ex_valid, "R1 ready/exit", {ready, ex_valid}, 2'b10);
    chk(!ipi_req && !eoi_req, "R1 pulses", {ipi_req, eoi_req}, 0);
    access(0, 12'h310, 0);
    chk(last_rd == 0, "R1 reset value", last_rd, 0);
  endtask

  task automatic t_allowed();
    access(1, 12'h310, 32'hA5A5_0001);
    chk(!ex_valid, "R2 write no exit", ex_valid, 0);
    access(0, 12'h310, 0);
    chk(last_rd == 32'hA5A5_0001, "R2 readback", last_rd, 32'hA5A5_0001);
    chk(!ex_valid, "R2 read no exit", ex_valid, 0);
  endtask

  task automatic t_accel_tpr_eoi();
    access(1, 12'h080, 32'h30);
    chk(!ex_valid && !ipi_req && !eoi_req, "R3 tpr write", {ex_valid, ipi_req, eoi_req}, 0);
    access(0, 12'h080, 0);
    chk(last_rd == 32'h30, "R3 tpr read", last_rd, 32'h30);
    access(1, 12'h0B0, 0);
    chk(eoi_req && !ex_valid, "R3 eoi pulse", {eoi_req, ex_valid}, 2'b10);
    @(negedge clk);
    chk(!eoi_req, "R3 eoi single cycle", eoi_req, 0);
  endtask

  task automatic t_icr_accel();
    ipi_ok = 1'b1;
    access(1, 12'h300, 32'h4041);
    chk(ipi_req && !ex_valid, "R4 ipi pulse", {ipi_req, ex_valid}, 2'b10);
    @(negedge clk);
    chk(!ipi_req, "R4 ipi single cycle", ipi_req, 0);
    access(0, 12'h300, 0);
    chk(last_rd == 32'h4041, "R4 stored", last_rd, 32'h4041);
  endtask

  task automatic t_icr_trap();
    ipi_ok = 1'b0;
    access(1, 12'h300, 32'h00C2);
    check_exit("R5 exit", 12'h401, 12'h300, 1, 1);
    chk(!ipi_req, "R5 no ipi", ipi_req, 0);
    do_ack();
    access(0, 12'h300, 0);
    chk(last_rd == 32'h00C2, "R5 stored", last_rd, 32'h00C2);
  endtask

  task automatic t_irr_fault();
    access(0, 12'h220, 0);
    chk(!ex_valid && last_rd == 0, "R6 irr read allowed", {ex_valid, last_rd[30:0]}, 0);
    access(1, 12'h220, 32'hFF);
    check_exit("R6 fault", 12'h402, 12'h220, 1, 0);
    do_ack();
    access(0, 12'h220, 0);
    chk(last_rd == 0 && !ex_valid, "R6 unchanged", last_rd, 0);
  endtask

  task automatic t_unlisted();
    access(0, 12'h400, 0);
    chk(last_rd == 0, "R7 fault read data", last_rd, 0);
    check_exit("R7 read fault", 12'h402, 12'h400, 0, 0);
    do_ack();
    access(1, 12'h084, 32'h99);
    check_exit("R7 misaligned write", 12'h402, 12'h084, 1, 0);
    do_ack();
    access(0, 12'h080, 0);
    chk(last_rd == 32'h30, "R7 store untouched", last_rd, 32'h30);
  endtask

  task automatic t_trap_id_ldr();
    access(1, 12'h020, 32'h0500_0000);
    check_exit("R8 id trap", 12'h402, 12'h020, 1, 1);
    do_ack();
    access(0, 12'h020, 0);
    chk(last_rd == 32'h0500_0000 && !ex_valid, "R8 id stored", last_rd, 32'h0500_0000);
    access(1, 12'h0D0, 32'h0100_0000);
    check_exit("R8 ldr trap", 12'h402, 12'h0D0, 1, 1);
    do_ack();
    access(0, 12'h0D0, 0);
    chk(last_rd == 32'h0100_0000, "R8 ldr stored", last_rd, 32'h0100_0000);
  endtask

  task automatic t_hold();
    access(1, 12'h500, 0);
    repeat (3) @(negedge clk);
    check_exit("R9 held", 12'h402, 12'h500, 1, 0);
    chk(!ready, "R9 stalled", ready, 0);
    valid = 1'b1; wr = 1'b1; off = 12'h310; wdata = 32'h1234;
    repeat (2) @(negedge clk);
    valid = 1'b0; wr = 1'b0;
    chk(ex_off == 12'h500 && ex_valid, "R9 exit unchanged", ex_off, 12'h500);
    do_ack();
    chk(!ex_valid && ready, "R9 ack clears", {ex_valid, ready}, 2'b01);
    access(0, 12'h310, 0);
    chk(last_rd == 32'hA5A5_0001, "R9 stalled write ignored", last_rd, 32'hA5A5_0001);
  endtask

  task automatic t_ack_collide();
    access(0, 12'h600, 0);
    chk(ex_valid, "R10 exit up", ex_valid, 1);
    ack = 1'b1; valid = 1'b1; wr = 1'b1; off = 12'h310; wdata = 32'h77;
    @(negedge clk);
    ack = 1'b0; valid = 1'b0; wr = 1'b0;
    chk(!ex_valid, "R10 exit cleared", ex_valid, 0);
    access(0, 12'h310, 0);
    chk(last_rd == 32'hA5A5_0001, "R10 colliding write not taken", last_rd, 32'hA5A5_0001);
    access(1, 12'h310, 32'h77);
    access(0, 12'h310, 0);
    chk(last_rd == 32'h77, "R10 later write taken", last_rd, 32'h77);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_allowed();
    t_accel_tpr_eoi();
    t_icr_accel();
    t_icr_trap();
    t_irr_fault();
    t_unlisted();
    t_trap_id_ldr();
    t_hold();
    t_ack_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule